// File: doc/BRIEF.md
# Monochrome Glyph Expansion Unit

This unit turns one-bit-per-pixel glyph rows into 32-bit colour pixels and writes them into a framebuffer through a simple synchronous memory port. It is meant for text and bitmap blits. The host first sets the drawing state: the glyph width, a packed start position, a per-row position increment, the foreground and background colours, the background mode and the raster operation. It then streams one pattern word per glyph row over a ready/valid handshake. Glyphs wider than one pattern word are sent by the host as separate column strips, each one begun by a fresh position write.

For each accepted word the unit draws the leading `width` bits of that word, most significant bit first, one pixel per bit, starting at the current position. It then adds the increment to the packed position, so the next word lands on the next row without the host sending a new address. In XOR mode every drawn pixel is read, combined with its colour and written back.

Top module: `glyph_expander`

## Requirements
- R1: After reset `pat_ready` is 1 and `fb_en` is 0. The drawing state is then width 32, position 0, increment 0x00010000, foreground 0xFFFFFFFF, background 0, opaque background and copy operation.
- R2: Configuration select 0 writes the width from `cfg_wdata[31:0]`. Values from 1 to 32 are stored, and any other value leaves the old width unchanged. Only the first `width` bits of each pattern word are drawn.
- R3: The position word carries X in bits 15:0 and Y in bits 31:16, written with select 1. Pixel i of a row goes to address `{Y[Y_BITS-1:0], (X+i) mod 2^X_BITS}`, so X wraps within a line and Y bits above `Y_BITS` are ignored.
- R4: Each accepted pattern word draws exactly one row, and bit 31 is the leftmost pixel.
- R5: After every row the 32-bit position gains the increment (select 2) with a full 32-bit add, so a carry out of X moves into Y. A position write replaces the running position, and the next row starts there.
- R6: In opaque mode a set bit draws the foreground (select 3) and a clear bit draws the background (select 4).
- R7: With bit 0 of the mode word (select 7) set, clear bits issue no framebuffer access and those pixels keep their contents.
- R8: Select 5 loads both colours in one write: foreground from `cfg_wdata[63:32]` and background from `cfg_wdata[31:0]`.
- R9: With raster-op byte 0x86 (select 6, bits 7:0), each drawn pixel becomes its colour XOR the old framebuffer value. The read is issued, nothing happens on the next cycle, and two cycles later a write goes to the same address. Any other raster-op byte selects plain copy.
- R10: `pat_ready` is high only while idle. A word is taken on a clock edge where `pat_valid` and `pat_ready` are both high, and `pat_ready` comes back once the row's last access has been issued. Configuration writes made while `pat_ready` is low are ignored.
- R11: A row takes one cycle per pixel in copy mode, whether or not the pixel is drawn. In XOR mode it takes three cycles per drawn pixel. `fb_rdata` must return the addressed word one cycle after a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 2*PIX_W | Configuration write data |
| pat_valid | input | 1 | Pattern word offered |
| pat_ready | output | 1 | Unit idle and able to take a pattern word |
| pat_data | input | PAT_W | Pattern word for one row, MSB leftmost |
| fb_en | output | 1 | Framebuffer access enable |
| fb_we | output | 1 | Framebuffer write (1) or read (0) |
| fb_addr | output | X_BITS+Y_BITS | Framebuffer pixel address {Y, X} |
| fb_wdata | output | PIX_W | Framebuffer write data |
| fb_rdata | input | PIX_W | Framebuffer read data, one cycle after a read |

## Verification
The hardest cases to reach from the ports are a configuration write that arrives while a row is in progress and the XOR read-modify-write path, where the result depends on what the framebuffer already holds. The bench loads the framebuffer model with a non-zero, address-dependent pattern. It then times a colour write for the cycle just after a slow XOR row has been accepted and checks that both that row and the following one use the old colour. Around these cases the bench sweeps every width from 1 to 32 and covers X wrap, the X-to-Y carry in the position add, and transparent mode. Each row is followed by a comparison of the whole framebuffer against an image computed in the bench.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

  typedef enum logic [2:0] {
    SEL_WIDTH = 3'd0,
    SEL_POS   = 3'd1,
    SEL_INC   = 3'd2,
    SEL_FG    = 3'd3,
    SEL_BG    = 3'd4,
    SEL_FGBG  = 3'd5,
    SEL_ROP   = 3'd6,
    SEL_MODE  = 3'd7
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PIX   = 2'd1,
    ST_RWAIT = 2'd2,
    ST_RWB   = 2'd3
  } eng_state_e;

  localparam logic [7:0]  ROP_COPY  = 8'h83;
  localparam logic [7:0]  ROP_XOR   = 8'h86;
  localparam logic [31:0] INC_RESET = 32'h0001_0000;

endpackage

// File: rtl/glyph_cfg_regs.sv
module glyph_cfg_regs
  import glyph_pkg::*;
#(
  parameter int PAT_W  = 32,
  parameter int PIX_W  = 32,
  parameter int X_BITS = 6,
  parameter int Y_BITS = 5,
  parameter int CNT_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [2*PIX_W-1:0] cfg_wdata,
  input  logic               cfg_open,
  input  logic               row_done,
  output logic [CNT_W-1:0]   width_q,
  output logic [X_BITS-1:0]  pos_x,
  output logic [Y_BITS-1:0]  pos_y,
  output logic [PIX_W-1:0]   fg_q,
  output logic [PIX_W-1:0]   bg_q,
  output logic               transp_q,
  output logic               xor_q
);

  localparam logic [31:0] WMAX = 32'(PAT_W);

  logic [31:0] pos_q;
  logic [31:0] inc_q;
  logic [7:0]  rop_q;
  logic [31:0] wval;
  logic        width_ok;

  assign wval     = cfg_wdata[31:0];
  assign width_ok = (wval != 32'd0) && (wval <= WMAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q  <= CNT_W'(PAT_W);
      pos_q    <= '0;
      inc_q    <= INC_RESET;
      fg_q     <= '1;
      bg_q     <= '0;
      transp_q <= 1'b0;
      rop_q    <= ROP_COPY;
    end else begin
      if (row_done) begin
        pos_q <= pos_q + inc_q;
      end
      if (cfg_we && cfg_open) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_WIDTH: if (width_ok) width_q <= wval[CNT_W-1:0];
          SEL_POS:   pos_q <= cfg_wdata[31:0];
          SEL_INC:   inc_q <= cfg_wdata[31:0];
          SEL_FG:    fg_q  <= cfg_wdata[PIX_W-1:0];
          SEL_BG:    bg_q  <= cfg_wdata[PIX_W-1:0];
          SEL_FGBG: begin
            fg_q <= cfg_wdata[2*PIX_W-1:PIX_W];
            bg_q <= cfg_wdata[PIX_W-1:0];
          end
          SEL_ROP:   rop_q    <= cfg_wdata[7:0];
          SEL_MODE:  transp_q <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  assign pos_x = pos_q[X_BITS-1:0];
  assign pos_y = pos_q[16 +: Y_BITS];
  assign xor_q = (rop_q == ROP_XOR);

endmodule

// File: rtl/glyph_pix_alu.sv
module glyph_pix_alu #(
  parameter int PIX_W = 32
) (
  input  logic             pix_bit,
  input  logic             transp,
  input  logic             use_old,
  input  logic [PIX_W-1:0] fg,
  input  logic [PIX_W-1:0] bg,
  input  logic [PIX_W-1:0] old,
  output logic             draw,
  output logic [PIX_W-1:0] colour
);

  logic [PIX_W-1:0] base;
  logic [PIX_W-1:0] mix;

  assign draw = pix_bit | ~transp;
  assign base = pix_bit ? fg : bg;

  for (genvar i = 0; i < PIX_W; i++) begin : g_mix
    assign mix[i] = use_old & old[i];
  end

  assign colour = base ^ mix;

endmodule

// File: rtl/glyph_row_engine.sv
module glyph_row_engine
  import glyph_pkg::*;
#(
  parameter int PAT_W  = 32,
  parameter int PIX_W  = 32,
  parameter int X_BITS = 6,
  parameter int Y_BITS = 5,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pat_valid,
  input  logic [PAT_W-1:0]  pat_data,
  output logic              pat_ready,
  input  logic [CNT_W-1:0]  width,
  input  logic [X_BITS-1:0] pos_x,
  input  logic [Y_BITS-1:0] pos_y,
  input  logic              transp,
  input  logic              xor_mode,
  input  logic [PIX_W-1:0]  fg,
  input  logic [PIX_W-1:0]  bg,
  input  logic [PIX_W-1:0]  fb_rdata,
  output logic              row_done,
  output logic              fb_en,
  output logic              fb_we,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [PIX_W-1:0]  fb_wdata
);

  eng_state_e        state_q;
  logic [PAT_W-1:0]  pat_q;
  logic [CNT_W-1:0]  col_q;
  logic [X_BITS-1:0] x_cur;
  logic [ADDR_W-1:0] addr_cur;
  logic              cur_bit;
  logic              last_pix;
  logic              draw;
  logic [PIX_W-1:0]  colour;
  logic              advance;

  assign cur_bit  = pat_q[PAT_W-1];
  assign x_cur    = pos_x + X_BITS'(col_q);
  assign addr_cur = {pos_y, x_cur};
  assign last_pix = (col_q == width - CNT_W'(1));

  glyph_pix_alu #(.PIX_W(PIX_W)) u_alu (
    .pix_bit (cur_bit),
    .transp  (transp),
    .use_old (xor_mode),
    .fg      (fg),
    .bg      (bg),
    .old     (fb_rdata),
    .draw    (draw),
    .colour  (colour)
  );

  assign advance  = ((state_q == ST_PIX) && !(draw && xor_mode)) ||
                    (state_q == ST_RWB);
  assign row_done = advance && last_pix;
  assign pat_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pat_q    <= '0;
      col_q    <= '0;
      fb_en    <= 1'b0;
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          fb_en <= 1'b0;
          fb_we <= 1'b0;
          if (pat_valid) begin
            pat_q   <= pat_data;
            col_q   <= '0;
            state_q <= ST_PIX;
          end
        end
        ST_PIX: begin
          fb_addr <= addr_cur;
          if (draw && xor_mode) begin
            fb_en   <= 1'b1;
            fb_we   <= 1'b0;
            state_q <= ST_RWAIT;
          end else begin
            fb_en    <= draw;
            fb_we    <= draw;
            fb_wdata <= colour;
          end
        end
        ST_RWAIT: begin
          fb_en   <= 1'b0;
          fb_we   <= 1'b0;
          state_q <= ST_RWB;
        end
        ST_RWB: begin
          fb_en    <= 1'b1;
          fb_we    <= 1'b1;
          fb_addr  <= addr_cur;
          fb_wdata <= colour;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (advance) begin
        pat_q <= pat_q << 1;
        col_q <= col_q + CNT_W'(1);
        if (last_pix) begin
          state_q <= ST_IDLE;
        end else begin
          state_q <= ST_PIX;
        end
      end
    end
  end

endmodule

// File: rtl/glyph_expander.sv
module glyph_expander
  import glyph_pkg::*;
#(
  parameter int PAT_W  = 32,
  parameter int PIX_W  = 32,
  parameter int X_BITS = 6,
  parameter int Y_BITS = 5,
  localparam int CNT_W  = $clog2(PAT_W + 1),
  localparam int ADDR_W = X_BITS + Y_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [2*PIX_W-1:0] cfg_wdata,
  input  logic               pat_valid,
  output logic               pat_ready,
  input  logic [PAT_W-1:0]   pat_data,
  output logic               fb_en,
  output logic               fb_we,
  output logic [ADDR_W-1:0]  fb_addr,
  output logic [PIX_W-1:0]   fb_wdata,
  input  logic [PIX_W-1:0]   fb_rdata
);

  logic [CNT_W-1:0]  width_q;
  logic [X_BITS-1:0] pos_x;
  logic [Y_BITS-1:0] pos_y;
  logic [PIX_W-1:0]  fg_q;
  logic [PIX_W-1:0]  bg_q;
  logic              transp_q;
  logic              xor_q;
  logic              row_done;

  glyph_cfg_regs #(
    .PAT_W(PAT_W), .PIX_W(PIX_W), .X_BITS(X_BITS), .Y_BITS(Y_BITS), .CNT_W(CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_open  (pat_ready),
    .row_done  (row_done),
    .width_q   (width_q),
    .pos_x     (pos_x),
    .pos_y     (pos_y),
    .fg_q      (fg_q),
    .bg_q      (bg_q),
    .transp_q  (transp_q),
    .xor_q     (xor_q)
  );

  glyph_row_engine #(
    .PAT_W(PAT_W), .PIX_W(PIX_W), .X_BITS(X_BITS), .Y_BITS(Y_BITS),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .pat_valid (pat_valid),
    .pat_data  (pat_data),
    .pat_ready (pat_ready),
    .width     (width_q),
    .pos_x     (pos_x),
    .pos_y     (pos_y),
    .transp    (transp_q),
    .xor_mode  (xor_q),
    .fg        (fg_q),
    .bg        (bg_q),
    .fb_rdata  (fb_rdata),
    .row_done  (row_done),
    .fb_en     (fb_en),
    .fb_we     (fb_we),
    .fb_addr   (fb_addr),
    .fb_wdata  (fb_wdata)
  );

endmodule

// File: rtl/glyph_expander_chk.sv
module glyph_expander_chk #(
  parameter int PAT_W  = 32,
  parameter int PIX_W  = 32,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              pat_valid,
  input logic              pat_ready,
  input logic              fb_en,
  input logic              fb_we,
  input logic [ADDR_W-1:0] fb_addr,
  input logic [CNT_W-1:0]  width_q,
  input logic [PIX_W-1:0]  fg_q,
  input logic [PIX_W-1:0]  bg_q
);

  // R1: reset leaves the unit idle with the memory port quiet
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (pat_ready && !fb_en));

  // R2: the stored width always lies in the legal range
  p_width_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (width_q != '0) && (width_q <= CNT_W'(PAT_W)));

  // R9: a read is followed by a silent cycle and then a write to the same pixel
  p_rmw_order_r9: assert property (@(posedge clk) disable iff (rst)
    (fb_en && !fb_we) |=> !fb_en ##1 (fb_en && fb_we && fb_addr == $past(fb_addr, 2)));

  // R10: taking a word drops ready on the next cycle
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (pat_valid && pat_ready) |=> !pat_ready);

  // R10: ready stays up while no word is offered
  p_ready_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (pat_ready && !pat_valid) |=> pat_ready);

  // R10: configuration written during a row leaves colours and width as they were
  p_cfg_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (!pat_ready && cfg_we) |=> ($stable(fg_q) && $stable(bg_q) && $stable(width_q)));

  // R10: a unit idle for two cycles running makes no memory access
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (pat_ready && $past(pat_ready)) |-> !fb_en);

endmodule

bind glyph_expander glyph_expander_chk #(
  .PAT_W(PAT_W), .PIX_W(PIX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .pat_valid (pat_valid),
  .pat_ready (pat_ready),
  .fb_en     (fb_en),
  .fb_we     (fb_we),
  .fb_addr   (fb_addr),
  .width_q   (width_q),
  .fg_q      (fg_q),
  .bg_q      (bg_q)
);

// File: tb/glyph_expander_test.sv
module glyph_expander_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAT_W  = 32;
  localparam int PIX_W  = 32;
  localparam int X_BITS = 6;
  localparam int Y_BITS = 5;
  localparam int ADDR_W = X_BITS + Y_BITS;
  localparam int DEPTH  = 1 << ADDR_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_we = 1'b0;
  logic [2:0]         cfg_sel = '0;
  logic [2*PIX_W-1:0] cfg_wdata = '0;
  logic               pat_valid = 1'b0;
  logic               pat_ready;
  logic [PAT_W-1:0]   pat_data = '0;
  logic               fb_en;
  logic               fb_we;
  logic [ADDR_W-1:0]  fb_addr;
  logic [PIX_W-1:0]   fb_wdata;
  logic [PIX_W-1:0]   fb_rdata;
  logic               init_req = 1'b0;

  logic [PIX_W-1:0] mem     [DEPTH];
  logic [PIX_W-1:0] ref_img [DEPTH];

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  int          m_width;
  logic [31:0] m_pos, m_inc, m_fg, m_bg;
  bit          m_transp, m_xor;

  glyph_expander #(.PAT_W(PAT_W), .PIX_W(PIX_W), .X_BITS(X_BITS), .Y_BITS(Y_BITS)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_data(pat_data),
    .fb_en(fb_en), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] seed_val(int i);
    return (32'(i) * 32'h0101_0101) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] pgen(int k);
    return (32'h9E37_79B9 * 32'(k + 1)) ^ (32'h7F4A_7C15 >> (k % 7));
  endfunction

  // framebuffer model: one-cycle read latency
  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seed_val(i);
    end else if (fb_en) begin
      if (fb_we) mem[fb_addr] <= fb_wdata;
      else       fb_rdata <= mem[fb_addr];
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_mem(string req);
    int bad = -1;
    for (int a = 0; a < DEPTH; a++) begin
      if (bad < 0 && mem[a] !== ref_img[a]) bad = a;
    end
    if (bad < 0) check(1'b1, req, "image", 32'd0, 32'd0);
    else check(1'b0, req, $sformatf("pixel at %0d", bad), mem[bad], ref_img[bad]);
  endtask

  task automatic set_reg(logic [2:0] sel, logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: if (data[31:0] >= 1 && data[31:0] <= 32) m_width = int'(data[31:0]);
      3'd1: m_pos = data[31:0];
      3'd2: m_inc = data[31:0];
      3'd3: m_fg = data[31:0];
      3'd4: m_bg = data[31:0];
      3'd5: begin m_fg = data[63:32]; m_bg = data[31:0]; end
      3'd6: m_xor = (data[7:0] == 8'h86);
      default: m_transp = data[0];
    endcase
  endtask

  task automatic model_row(logic [31:0] pat);
    for (int i = 0; i < m_width; i++) begin
      logic [15:0] x;
      logic [ADDR_W-1:0] a;
      logic [31:0] c;
      logic b;
      x = m_pos[15:0] + 16'(i);
      a = {m_pos[16 +: Y_BITS], x[X_BITS-1:0]};
      b = pat[31 - i];
      if (b || !m_transp) begin
        c = b ? m_fg : m_bg;
        if (m_xor) c = c ^ ref_img[a];
        ref_img[a] = c;
      end
    end
    m_pos = m_pos + m_inc;
  endtask

  // sends one row; optionally writes a config register on the first busy cycle
  task automatic send_row(logic [31:0] pat, bit busy_cfg, logic [2:0] bsel,
                          logic [63:0] bdata, output int busy);
    busy = 0;
    @(negedge clk);
    while (!pat_ready) @(negedge clk);
    pat_valid = 1'b1; pat_data = pat;
    @(negedge clk);
    pat_valid = 1'b0;
    check(!pat_ready, "R10", "ready after accept", 32'(pat_ready), 32'd0);
    if (busy_cfg) begin
      cfg_we = 1'b1; cfg_sel = bsel; cfg_wdata = bdata;
    end
    while (!pat_ready) begin
      busy++;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    cfg_we = 1'b0;
    model_row(pat);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int busy;
    init_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    init_req = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) ref_img[i] = seed_val(i);
    m_width = 32; m_pos = 32'd0; m_inc = 32'h0001_0000;
    m_fg = 32'hFFFF_FFFF; m_bg = 32'd0; m_transp = 1'b0; m_xor = 1'b0;

    // R1: reset state at the ports
    @(negedge clk);
    check(pat_ready === 1'b1, "R1", "pat_ready after reset", 32'(pat_ready), 32'd1);
    check(fb_en === 1'b0, "R1", "fb_en after reset", 32'(fb_en), 32'd0);

    // R1 R4 R6: a row drawn with the reset drawing state
    send_row(32'hF0F0_1234, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R1");
    check(busy == 32, "R11", "copy row cycles", 32'(busy), 32'd32);

    // R8: both colours in one write; R2 R4 R5 R6: every width
    set_reg(3'd5, {32'h0011_2233, 32'h00AA_BBCC});
    set_reg(3'd1, {32'd0, 16'd2, 16'd5});
    for (int w = 1; w <= 32; w++) begin
      set_reg(3'd0, 64'(w));
      send_row(pgen(w), 1'b0, 3'd0, 64'd0, busy);
      compare_mem((w % 2) ? "R2" : "R8");
      if (w == 7) check(busy == 7, "R11", "copy row cycles w7", 32'(busy), 32'd7);
    end

    // R2: out-of-range widths leave the width unchanged
    set_reg(3'd0, 64'd12);
    set_reg(3'd0, 64'd0);
    set_reg(3'd0, 64'd33);
    send_row(32'hFFFF_FFFF, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R2");
    check(busy == 12, "R2", "width kept at 12", 32'(busy), 32'd12);

    // R3 R5: position restart, X wrap, high Y bits ignored
    set_reg(3'd0, 64'd10);
    set_reg(3'd1, {32'd0, 16'h0043, 16'hFFFC});
    send_row(32'hDEAD_BEEF, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R3");
    send_row(32'h1234_5678, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R3");
    set_reg(3'd2, 64'h0001_0003);
    for (int k = 0; k < 3; k++) begin
      send_row(pgen(40 + k), 1'b0, 3'd0, 64'd0, busy);
      compare_mem("R5");
    end
    // R5: carry from X into Y
    set_reg(3'd2, 64'h0000_0008);
    set_reg(3'd1, {32'd0, 16'h0007, 16'hFFFC});
    send_row(32'hAAAA_5555, 1'b0, 3'd0, 64'd0, busy);
    send_row(32'h5555_AAAA, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R5");

    // R7: transparent background
    set_reg(3'd2, 64'h0001_0000);
    set_reg(3'd0, 64'd32);
    set_reg(3'd7, 64'd1);
    set_reg(3'd1, {32'd0, 16'd10, 16'd16});
    for (int k = 0; k < 6; k++) begin
      send_row(pgen(60 + k), 1'b0, 3'd0, 64'd0, busy);
      compare_mem("R7");
    end
    check(busy == 32, "R11", "transparent row cycles", 32'(busy), 32'd32);

    // R9: XOR with existing contents, opaque then transparent
    set_reg(3'd7, 64'd0);
    set_reg(3'd6, 64'h86);
    set_reg(3'd0, 64'd9);
    send_row(32'hFFFF_FFFF, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R9");
    check(busy == 27, "R11", "xor row cycles", 32'(busy), 32'd27);
    for (int k = 0; k < 4; k++) begin
      send_row(pgen(80 + k), 1'b0, 3'd0, 64'd0, busy);
      compare_mem("R9");
    end
    set_reg(3'd7, 64'd1);
    set_reg(3'd0, 64'd32);
    send_row(32'hC3C3_0FF0, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R9");

    // R10: colour write during a row is ignored (row and next row keep old fg)
    set_reg(3'd7, 64'd0);
    set_reg(3'd1, {32'd0, 16'd20, 16'd0});
    send_row(32'hF00F_A55A, 1'b1, 3'd3, 64'h0000_0000_1357_2468, busy);
    compare_mem("R10");
    send_row(32'h0FF0_5AA5, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R10");

    // R9: other raster-op bytes fall back to copy
    set_reg(3'd6, 64'h85);
    send_row(32'h8001_8001, 1'b0, 3'd0, 64'd0, busy);
    compare_mem("R9");
    check(busy == 32, "R9", "copy after rop change", 32'(busy), 32'd32);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule